// File: doc/BRIEF.md
# Exception Entry Sequencer

This block works out what a processor core must do when it enters an exception. It handles three sources: an undefined-instruction trap, a software interrupt and an external interrupt request. In the cycle a request is seen, the block takes the current program counter, the status word and the high-vector control bit. One clock edge later it presents the results of the entry as registered outputs. These are the new processor mode, the return address for the link register, the vector address, the status value to save for the new mode, and the updated status word.

The block also reports two events. A bank-swap strobe tells an external banked register file that the new mode uses a different register bank from the old one. A wake pulse clears the core's halt flag when an interrupt is taken. Fetching from the vector and swapping registers are left to the surrounding logic.

The status word layout is as follows. Bits [4:0] hold the mode, with 0x10 user, 0x11 fast interrupt, 0x12 interrupt, 0x13 supervisor, 0x17 abort, 0x1B undefined and 0x1F system. Bit 5 is the 16-bit-instruction-state flag. Bit 7 is the interrupt-disable flag.

Top module: `exc_entry_seq`

## Requirements
- R1: An interrupt request while status bit 7 is set is ignored completely: if no other request is present, take_o stays 0 in the next cycle and every other output is 0.
- R2: At most one exception is taken per cycle, with priority undefined over software interrupt over interrupt. kind_o encodes the one taken: 1 undefined, 2 software interrupt, 3 interrupt, 0 none.
- R3: The new mode is 0x12 for an interrupt, 0x13 for a software interrupt and 0x1B for an undefined trap. It appears in new_mode_o and in bits [4:0] of status_o.
- R4: Let W be 2 when status bit 5 is set and 4 otherwise. link_o is pc_i − W + 4 for an interrupt and pc_i − W for the other two kinds, computed modulo 2^32.
- R5: saved_status_o equals the status word that was presented with the request. status_o keeps every bit of that word except the mode field and bits 5 and 7.
- R6: vector_o is 0x04 for undefined, 0x08 for software interrupt and 0x18 for interrupt. When hivec_i was set with the request, the vector is ORed with 0xFFFF0000.
- R7: On every entry, bit 5 of status_o is 0 (32-bit state) and bit 7 of status_o is 1.
- R8: wake_o pulses for one cycle exactly when an interrupt is taken. It stays 0 for the other two kinds.
- R9: bank_swap_o is 1 on an entry whose old and new modes use different register banks. User and system modes share one bank, and every other mode has its own bank.
- R10: All results appear one clock after the request cycle. In a cycle with no entry, and after synchronous reset, all outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_irq | input | 1 | Interrupt request |
| req_swi | input | 1 | Software interrupt request |
| req_und | input | 1 | Undefined-instruction trap request |
| pc_i | input | 32 | Current program counter |
| status_i | input | 32 | Current status word |
| hivec_i | input | 1 | Relocate vectors high |
| take_o | output | 1 | An exception entry result is valid |
| kind_o | output | 2 | Kind taken (0 none, 1 undefined, 2 software interrupt, 3 interrupt) |
| new_mode_o | output | 5 | Mode entered |
| link_o | output | 32 | Return address for the link register |
| vector_o | output | 32 | Vector address to fetch from |
| saved_status_o | output | 32 | Status to store in the new mode's saved status register |
| status_o | output | 32 | Updated status word |
| bank_swap_o | output | 1 | Register bank changes with this entry |
| wake_o | output | 1 | Clear the halt flag |

## Verification
Two functions can fall in the same cycle: arbitration among simultaneous requests, and the interrupt mask that removes the interrupt from that contest. The bench provokes this in two ways. Directed vectors raise all three lines at once, the software interrupt together with the interrupt, and a masked interrupt together with a software interrupt. Long random runs then set every request line and the disable bit independently. A behavioural model picks the winner, and each cycle the kind, link address, vector and wake pulse are compared with that winner's values.

// File: rtl/exc_entry_pkg.sv
package exc_entry_pkg;

  typedef enum logic [1:0] {
    EK_NONE = 2'd0,
    EK_UND  = 2'd1,
    EK_SWI  = 2'd2,
    EK_IRQ  = 2'd3
  } exc_kind_e;

  localparam int MODE_W = 5;

  localparam logic [MODE_W-1:0] MD_USR = 5'h10;
  localparam logic [MODE_W-1:0] MD_FIQ = 5'h11;
  localparam logic [MODE_W-1:0] MD_IRQ = 5'h12;
  localparam logic [MODE_W-1:0] MD_SVC = 5'h13;
  localparam logic [MODE_W-1:0] MD_ABT = 5'h17;
  localparam logic [MODE_W-1:0] MD_UND = 5'h1B;
  localparam logic [MODE_W-1:0] MD_SYS = 5'h1F;

  typedef enum logic [2:0] {
    BK_SHARED = 3'd0,
    BK_FIQ    = 3'd1,
    BK_IRQ    = 3'd2,
    BK_SVC    = 3'd3,
    BK_ABT    = 3'd4,
    BK_UND    = 3'd5
  } bank_e;

  function automatic bank_e bank_of(input logic [MODE_W-1:0] m);
    case (m)
      MD_FIQ:  return BK_FIQ;
      MD_IRQ:  return BK_IRQ;
      MD_SVC:  return BK_SVC;
      MD_ABT:  return BK_ABT;
      MD_UND:  return BK_UND;
      default: return BK_SHARED;
    endcase
  endfunction

  function automatic logic [MODE_W-1:0] mode_for(input exc_kind_e k);
    case (k)
      EK_IRQ:  return MD_IRQ;
      EK_SWI:  return MD_SVC;
      EK_UND:  return MD_UND;
      default: return '0;
    endcase
  endfunction

endpackage

// File: rtl/exc_arbiter.sv
module exc_arbiter
  import exc_entry_pkg::*;
#(
  parameter int SW    = 32,
  parameter int I_BIT = 7
) (
  input  logic          req_irq,
  input  logic          req_swi,
  input  logic          req_und,
  input  logic [SW-1:0] status,
  output exc_kind_e     kind
);
  logic irq_ok;

  assign irq_ok = req_irq && !status[I_BIT];

  always_comb begin
    if (req_und)      kind = EK_UND;
    else if (req_swi) kind = EK_SWI;
    else if (irq_ok)  kind = EK_IRQ;
    else              kind = EK_NONE;
  end
endmodule

// File: rtl/exc_addr_calc.sv
module exc_addr_calc
  import exc_entry_pkg::*;
#(
  parameter int          AW       = 32,
  parameter int          SW       = 32,
  parameter int          T_BIT    = 5,
  parameter int          NARROW_W = 2,
  parameter int          WIDE_W   = 4,
  parameter logic [7:0]  VEC_UND  = 8'h04,
  parameter logic [7:0]  VEC_SWI  = 8'h08,
  parameter logic [7:0]  VEC_IRQ  = 8'h18,
  parameter int          HI_BITS  = 16
) (
  input  exc_kind_e     kind,
  input  logic [AW-1:0] pc,
  input  logic [SW-1:0] status,
  input  logic          hivec,
  output logic [AW-1:0] link,
  output logic [AW-1:0] vector
);
  localparam logic [AW-1:0] NARROW = AW'(NARROW_W);
  localparam logic [AW-1:0] WIDE   = AW'(WIDE_W);
  localparam logic [AW-1:0] HI_OR  = {{HI_BITS{1'b1}}, {(AW-HI_BITS){1'b0}}};

  logic [AW-1:0] width;
  logic [AW-1:0] back;
  logic [AW-1:0] base;

  assign width = status[T_BIT] ? NARROW : WIDE;
  assign back  = pc - width;

  always_comb begin
    case (kind)
      EK_IRQ:  begin link = back + WIDE; base = AW'(VEC_IRQ); end
      EK_SWI:  begin link = back;        base = AW'(VEC_SWI); end
      EK_UND:  begin link = back;        base = AW'(VEC_UND); end
      default: begin link = '0;          base = '0;           end
    endcase
  end

  assign vector = hivec ? (base | HI_OR) : base;
endmodule

// File: rtl/exc_status_upd.sv
module exc_status_upd
  import exc_entry_pkg::*;
#(
  parameter int SW    = 32,
  parameter int T_BIT = 5,
  parameter int I_BIT = 7
) (
  input  exc_kind_e         kind,
  input  logic [SW-1:0]     status,
  output logic [MODE_W-1:0] new_mode,
  output logic [SW-1:0]     new_status,
  output logic              bank_swap
);
  logic [MODE_W-1:0] old_mode;

  assign old_mode = status[MODE_W-1:0];
  assign new_mode = mode_for(kind);

  always_comb begin
    new_status               = status;
    new_status[MODE_W-1:0]   = new_mode;
    new_status[T_BIT]        = 1'b0;
    new_status[I_BIT]        = 1'b1;
  end

  assign bank_swap = (kind != EK_NONE) && (bank_of(old_mode) != bank_of(new_mode));
endmodule

// File: rtl/exc_entry_seq.sv
module exc_entry_seq
  import exc_entry_pkg::*;
#(
  parameter int AW    = 32,
  parameter int SW    = 32,
  parameter int T_BIT = 5,
  parameter int I_BIT = 7
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_irq,
  input  logic              req_swi,
  input  logic              req_und,
  input  logic [AW-1:0]     pc_i,
  input  logic [SW-1:0]     status_i,
  input  logic              hivec_i,
  output logic              take_o,
  output logic [1:0]        kind_o,
  output logic [MODE_W-1:0] new_mode_o,
  output logic [AW-1:0]     link_o,
  output logic [AW-1:0]     vector_o,
  output logic [SW-1:0]     saved_status_o,
  output logic [SW-1:0]     status_o,
  output logic              bank_swap_o,
  output logic              wake_o
);
  exc_kind_e         kind;
  logic [AW-1:0]     link_c;
  logic [AW-1:0]     vec_c;
  logic [MODE_W-1:0] mode_c;
  logic [SW-1:0]     stat_c;
  logic              swap_c;
  logic              take_c;

  exc_arbiter #(.SW(SW), .I_BIT(I_BIT)) arb_i (
    .req_irq(req_irq), .req_swi(req_swi), .req_und(req_und),
    .status(status_i), .kind(kind)
  );

  exc_addr_calc #(.AW(AW), .SW(SW), .T_BIT(T_BIT)) addr_i (
    .kind(kind), .pc(pc_i), .status(status_i), .hivec(hivec_i),
    .link(link_c), .vector(vec_c)
  );

  exc_status_upd #(.SW(SW), .T_BIT(T_BIT), .I_BIT(I_BIT)) stat_i (
    .kind(kind), .status(status_i), .new_mode(mode_c),
    .new_status(stat_c), .bank_swap(swap_c)
  );

  assign take_c = (kind != EK_NONE);

  always_ff @(posedge clk) begin
    if (rst || !take_c) begin
      take_o         <= 1'b0;
      kind_o         <= 2'd0;
      new_mode_o     <= '0;
      link_o         <= '0;
      vector_o       <= '0;
      saved_status_o <= '0;
      status_o       <= '0;
      bank_swap_o    <= 1'b0;
      wake_o         <= 1'b0;
    end else begin
      take_o         <= 1'b1;
      kind_o         <= kind;
      new_mode_o     <= mode_c;
      link_o         <= link_c;
      vector_o       <= vec_c;
      saved_status_o <= status_i;
      status_o       <= stat_c;
      bank_swap_o    <= swap_c;
      wake_o         <= (kind == EK_IRQ);
    end
  end
endmodule

// File: rtl/exc_entry_chk.sv
module exc_entry_chk #(
  parameter int AW    = 32,
  parameter int SW    = 32,
  parameter int T_BIT = 5,
  parameter int I_BIT = 7
) (
  input logic          clk,
  input logic          rst,
  input logic          req_irq,
  input logic          req_swi,
  input logic          req_und,
  input logic [SW-1:0] status_i,
  input logic          hivec_i,
  input logic          take_o,
  input logic [1:0]    kind_o,
  input logic [AW-1:0] vector_o,
  input logic [SW-1:0] saved_status_o,
  input logic [SW-1:0] status_o,
  input logic          wake_o
);
  a_r1_masked_irq: assert property (@(posedge clk) disable iff (rst)
    (req_irq && !req_swi && !req_und && status_i[I_BIT]) |=> !take_o);

  a_r2_und_wins: assert property (@(posedge clk) disable iff (rst)
    req_und |=> (take_o && kind_o == 2'd1));

  a_r2_swi_over_irq: assert property (@(posedge clk) disable iff (rst)
    (req_swi && !req_und) |=> (take_o && kind_o == 2'd2));

  a_r5_saved_status: assert property (@(posedge clk) disable iff (rst)
    (req_und || req_swi) |=> (saved_status_o == $past(status_i)));

  a_r6_high_vector: assert property (@(posedge clk) disable iff (rst)
    ((req_und || req_swi) && hivec_i) |=> (vector_o[AW-1:AW-16] == 16'hFFFF));

  a_r7_state_forced: assert property (@(posedge clk) disable iff (rst)
    take_o |-> (!status_o[T_BIT] && status_o[I_BIT]));

  a_r8_wake_irq_only: assert property (@(posedge clk) disable iff (rst)
    wake_o |-> (take_o && kind_o == 2'd3));
endmodule

bind exc_entry_seq exc_entry_chk #(.AW(AW), .SW(SW), .T_BIT(T_BIT), .I_BIT(I_BIT)) chk_i (
  .clk(clk), .rst(rst), .req_irq(req_irq), .req_swi(req_swi), .req_und(req_und),
  .status_i(status_i), .hivec_i(hivec_i), .take_o(take_o), .kind_o(kind_o),
  .vector_o(vector_o), .saved_status_o(saved_status_o), .status_o(status_o),
  .wake_o(wake_o)
);

// File: tb/exc_entry_seq_tb.sv
module exc_entry_seq_tb_top;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        req_irq = 1'b0, req_swi = 1'b0, req_und = 1'b0;
  logic [31:0] pc_i = '0, status_i = '0;
  logic        hivec_i = 1'b0;
  logic        take_o, bank_swap_o, wake_o;
  logic [1:0]  kind_o;
  logic [4:0]  new_mode_o;
  logic [31:0] link_o, vector_o, saved_status_o, status_o;

  int vectors = 0;
  int miscompares = 0;
  bit done = 1'b0;

  logic        e_take, e_swap, e_wake;
  logic [1:0]  e_kind;
  logic [4:0]  e_mode;
  logic [31:0] e_link, e_vec, e_saved, e_stat;

  always #(CLK_PERIOD/2) clk = ~clk;

  exc_entry_seq dut_i (
    .clk(clk), .rst(rst), .req_irq(req_irq), .req_swi(req_swi), .req_und(req_und),
    .pc_i(pc_i), .status_i(status_i), .hivec_i(hivec_i),
    .take_o(take_o), .kind_o(kind_o), .new_mode_o(new_mode_o), .link_o(link_o),
    .vector_o(vector_o), .saved_status_o(saved_status_o), .status_o(status_o),
    .bank_swap_o(bank_swap_o), .wake_o(wake_o)
  );

  function automatic int bank_id(input logic [4:0] m);
    if (m == 5'h10 || m == 5'h1F) return 0;
    if (m == 5'h11 || m == 5'h12 || m == 5'h13 || m == 5'h17 || m == 5'h1B) return m;
    return 0;
  endfunction

  // Behavioural model of one request cycle
  task automatic model(input logic ri, rs, ru, input logic [31:0] pc, st, input logic hv);
    int w;
    int k;
    if (ru) k = 1;
    else if (rs) k = 2;
    else if (ri && !st[7]) k = 3;
    else k = 0;
    w = st[5] ? 2 : 4;
    e_take = 0; e_kind = 0; e_mode = 0; e_link = 0; e_vec = 0;
    e_saved = 0; e_stat = 0; e_swap = 0; e_wake = 0;
    if (k != 0) begin
      e_take = 1;
      e_kind = 2'(k);
      e_mode = (k == 3) ? 5'h12 : (k == 2) ? 5'h13 : 5'h1B;
      e_link = (k == 3) ? pc - 32'(w) + 32'd4 : pc - 32'(w);
      e_vec  = (k == 3) ? 32'h18 : (k == 2) ? 32'h08 : 32'h04;
      if (hv) e_vec = e_vec | 32'hFFFF0000;
      e_saved = st;
      e_stat  = {st[31:8], 1'b1, st[6], 1'b0, e_mode};
      e_swap  = (bank_id(st[4:0]) != bank_id(e_mode));
      e_wake  = (k == 3);
    end
  endtask

  task automatic cmp(input string tag, input logic [31:0] act, exp);
    vectors++;
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic check_all();
    cmp("R2 take",     32'(take_o), 32'(e_take));
    cmp("R2 kind",     32'(kind_o), 32'(e_kind));
    cmp("R3 mode",     32'(new_mode_o), 32'(e_mode));
    cmp("R4 link",     link_o, e_link);
    cmp("R6 vector",   vector_o, e_vec);
    cmp("R5 saved",    saved_status_o, e_saved);
    cmp("R7 status",   status_o, e_stat);
    cmp("R9 bankswap", 32'(bank_swap_o), 32'(e_swap));
    cmp("R8 wake",     32'(wake_o), 32'(e_wake));
  endtask

  // Drive at negedge, check the previous vector's results at the following negedge
  task automatic apply(input logic ri, rs, ru, input logic [31:0] pc, st, input logic hv);
    req_irq = ri; req_swi = rs; req_und = ru; pc_i = pc; status_i = st; hivec_i = hv;
    model(ri, rs, ru, pc, st, hv);
    @(negedge clk);
    check_all();
  endtask

  initial begin
    int wd = 0;
    while (!done && wd < 100000) begin
      @(posedge clk);
      wd++;
    end
    if (!done) begin
      miscompares++;
      vectors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

  initial begin
    logic [4:0] modes [7] = '{5'h10, 5'h11, 5'h12, 5'h13, 5'h17, 5'h1B, 5'h1F};
    repeat (3) @(negedge clk);
    // R10: reset state, with a request present while reset is held
    req_und = 1'b1;
    @(negedge clk);
    model(0, 0, 0, 0, 0, 0);
    check_all();
    req_und = 1'b0;
    rst = 1'b0;
    @(negedge clk);
    check_all();

    apply(1, 0, 0, 32'h100, 32'h1F, 0);        // R4 interrupt, 32-bit state: link 0x100
    apply(1, 0, 0, 32'h100, 32'h3F, 0);        // R4 interrupt, 16-bit state: link 0x102
    apply(0, 1, 0, 32'h100, 32'h10, 0);        // R4 software interrupt: link 0xFC
    apply(0, 1, 0, 32'h100, 32'h30, 0);        // R4 software interrupt, 16-bit: link 0xFE
    apply(0, 0, 1, 32'h200, 32'h13, 1);        // R6 undefined, high vectors
    apply(1, 1, 1, 32'h400, 32'h1F, 0);        // R2 all three: undefined wins
    apply(1, 1, 0, 32'h400, 32'h1F, 1);        // R2 software interrupt beats interrupt
    apply(1, 0, 0, 32'h400, 32'h9F, 0);        // R1 masked interrupt ignored
    apply(1, 1, 0, 32'h400, 32'h9F, 0);        // R1 masked interrupt with a software interrupt
    apply(0, 1, 0, 32'h0, 32'h10, 0);          // R4 wrap-around: link 0xFFFFFFFC
    apply(1, 0, 0, 32'h800, 32'h12, 1);        // R9 interrupt while in interrupt mode: no swap
    apply(0, 1, 0, 32'h800, 32'h13, 0);        // R9 supervisor to supervisor: no swap
    apply(0, 0, 0, 32'h800, 32'h13, 1);        // R10 idle cycle: all zero

    for (int i = 0; i < 3000; i++) begin
      logic [31:0] st;
      logic [2:0]  r;
      r  = 3'($urandom_range(0, 7));
      st = $urandom;
      st[4:0] = modes[$urandom_range(0, 6)];
      apply(r[0], r[1] & ($urandom_range(0, 2) == 0), r[2] & ($urandom_range(0, 3) == 0),
            $urandom, st, 1'($urandom_range(0, 1)));
    end
    apply(0, 0, 0, 0, 0, 0);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule